// File: doc/BRIEF.md
# GF(4096) Composite-Field Multiplier

This block multiplies two 12-bit symbols of GF(2^12), the field that a Reed-Solomon engine uses for 12-bit symbols. The symbols are not reduced by a single degree-12 polynomial. Each symbol is a degree-1 polynomial over GF(64), with coefficients in the six-bit halves. The extension is taken modulo Y^2 + Y + 0x21, and GF(64) itself uses x^6 + x + 1. Three GF(64) products of the halves form the result, and a fourth multiplies by the fixed coefficient 0x21.

A second mode advances a symbol by one primitive-element step, which is multiplication by the fixed symbol 0xE01. An input of zero is taken to give 0x001. A code generator or a syndrome stepper can use this mode to walk through the powers of the primitive element. By default the result is registered, so an operation presented with `in_valid` returns its product with `out_valid` on the next cycle. Setting the parameter `REGISTERED` to 0 gives a purely combinational path.

Top module: `gf4096_mult`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_prod` are cleared to 0 at that edge.
- R2: Each GF(64) sub-product reduces modulo x^6+x+1, so for example 0x002 times 0x020 gives 0x003, and 0x03F squared gives 0x02A.
- R3: Bits 11:6 of an operand are its high half and bits 5:0 its low half. 0x040 is the extension generator, and 0x040 times 0x040 gives 0x061.
- R4: High result half = (ah^al)(bh^bl) ^ al·bl, and low result half = (ah·bh)·0x21 ^ al·bl, with all products in GF(64). For example 0xFFF times 0x040 gives 0x03E.
- R5: 0x001 is the multiplicative identity, and a zero operand gives 0x000.
- R6: With `REGISTERED`=1, `out_valid` in a cycle equals `in_valid` of the previous cycle, and `out_prod` carries that operation's result.
- R7: When `in_valid` is low, `out_prod` keeps its previous value.
- R8: With `in_step`=1 the result is `in_a` times 0xE01, and `in_b` is ignored. If `in_a` is 0x000 the result is 0x001. For example 0x001 gives 0xE01 and 0x040 gives 0xE5C.
- R9: The product does not depend on operand order: a·b equals b·a for all operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_step | input | 1 | 1: primitive-element step of `in_a`; 0: `in_a`·`in_b` |
| in_a | input | 12 | First operand |
| in_b | input | 12 | Second operand (ignored in step mode) |
| out_valid | output | 1 | Result valid |
| out_prod | output | 12 | Product |

## Verification
Both high halves must be nonzero before the term ah·bh·0x21 contributes, and neither the identity nor the zero vectors can reveal a wrong reduction constant there. The stimulus table therefore includes 0x040 squared and 0xFFF times 0x040, in which only that term survives. An LFSR sweep then drives full 12-bit operand pairs and compares every result against a reference model in the bench. That model forms the GF(64) products by an unreduced carry-less multiply followed by top-down reduction. Each pair is also applied with its operands swapped.

// File: rtl/gf4096_pkg.sv
package gf4096_pkg;

    localparam int HALF_W = 6;
    localparam int SYM_W  = 2 * HALF_W;

    // x^6 = x + 1 : low bits of the GF(64) reduction polynomial
    localparam logic [HALF_W-1:0] RED_LOW  = 6'h03;
    // constant coefficient of the extension polynomial Y^2 + Y + c
    localparam logic [HALF_W-1:0] EXT_C    = 6'h21;
    // multiplier for one primitive-element step
    localparam logic [SYM_W-1:0]  STEP_K   = 12'hE01;
    localparam logic [SYM_W-1:0]  SYM_ONE  = 12'h001;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } sym_t;

    // multiply a GF(64) element by x, reducing at once
    function automatic logic [HALF_W-1:0] xtime6(input logic [HALF_W-1:0] v);
        return {v[HALF_W-2:0], 1'b0} ^ (v[HALF_W-1] ? RED_LOW : '0);
    endfunction

endpackage

// File: rtl/gf64_mul_unit.sv
module gf64_mul_unit
    import gf4096_pkg::*;
(
    input  logic [HALF_W-1:0] a,
    input  logic [HALF_W-1:0] b,
    output logic [HALF_W-1:0] p
);

    // acc[i]: sum of a[j]*b*x^j for j < i ; sh[i] = b*x^i
    logic [HALF_W-1:0] acc [0:HALF_W];
    logic [HALF_W-1:0] sh  [0:HALF_W-1];

    assign acc[0] = '0;
    assign sh[0]  = b;

    for (genvar i = 0; i < HALF_W; i++) begin : g_step
        assign acc[i+1] = a[i] ? (acc[i] ^ sh[i]) : acc[i];
        if (i < HALF_W - 1) begin : g_shift
            assign sh[i+1] = xtime6(sh[i]);
        end
    end

    assign p = acc[HALF_W];

endmodule

// File: rtl/gf4096_core.sv
module gf4096_core
    import gf4096_pkg::*;
(
    input  sym_t a,
    input  sym_t b,
    output sym_t p
);

    logic [HALF_W-1:0] sum_prod;   // (ah^al)(bh^bl)
    logic [HALF_W-1:0] low_prod;   // al*bl
    logic [HALF_W-1:0] high_prod;  // ah*bh
    logic [HALF_W-1:0] high_red;   // ah*bh*c

    gf64_mul_unit u_sum (
        .a (a.hi ^ a.lo),
        .b (b.hi ^ b.lo),
        .p (sum_prod)
    );

    gf64_mul_unit u_low (
        .a (a.lo),
        .b (b.lo),
        .p (low_prod)
    );

    gf64_mul_unit u_high (
        .a (a.hi),
        .b (b.hi),
        .p (high_prod)
    );

    gf64_mul_unit u_fold (
        .a (high_prod),
        .b (EXT_C),
        .p (high_red)
    );

    assign p.hi = sum_prod ^ low_prod;
    assign p.lo = high_red ^ low_prod;

endmodule

// File: rtl/gf4096_mult.sv
module gf4096_mult
    import gf4096_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_step,
    input  logic [SYM_W-1:0] in_a,
    input  logic [SYM_W-1:0] in_b,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_prod
);

    sym_t             op_a;
    sym_t             op_b;
    sym_t             core_p;
    logic [SYM_W-1:0] res_d;

    assign op_a = in_a;
    assign op_b = in_step ? STEP_K : in_b;

    gf4096_core u_core (
        .a (op_a),
        .b (op_b),
        .p (core_p)
    );

    // stepping from zero restarts the power sequence at one
    assign res_d = (in_step && (in_a == '0)) ? SYM_ONE : core_p;

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_prod  <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    out_prod <= res_d;
                end
            end
        end

        a_r6_valid_rise: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        a_r6_valid_idle: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        a_r7_hold: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> $stable(out_prod));
        a_r8_zero_step: assert property (@(posedge clk) disable iff (rst)
            (in_valid && in_step && in_a == '0) |=> out_prod == SYM_ONE);
        a_r5_identity: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_step && in_b == SYM_ONE) |=> out_prod == $past(in_a));
        a_r5_zero: assert property (@(posedge clk) disable iff (rst)
            (in_valid && !in_step && (in_a == '0 || in_b == '0)) |=> out_prod == '0);
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_prod  = res_d;
    end

endmodule

// File: tb/gf4096_mult_tb.sv
`timescale 1ns/1ps
module gf4096_mult_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic        in_step;
    logic [11:0] in_a;
    logic [11:0] in_b;
    logic        out_valid;
    logic [11:0] out_prod;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gf4096_mult dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_step   (in_step),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_prod  (out_prod)
    );

    // {step, a, b, expected}
    localparam int NV = 9;
    localparam logic [36:0] VEC [NV] = '{
        {1'b0, 12'hABC, 12'h001, 12'hABC},   // R5 identity
        {1'b0, 12'hABC, 12'h000, 12'h000},   // R5 zero
        {1'b0, 12'h002, 12'h020, 12'h003},   // R2 x*x^5
        {1'b0, 12'h040, 12'h040, 12'h061},   // R3 generator squared
        {1'b0, 12'h03F, 12'h03F, 12'h02A},   // R2 square in low half
        {1'b0, 12'hFFF, 12'h040, 12'h03E},   // R4 folded high term
        {1'b1, 12'h000, 12'h5A5, 12'h001},   // R8 zero restart
        {1'b1, 12'h001, 12'h123, 12'hE01},   // R8 step of one
        {1'b1, 12'h040, 12'hFFF, 12'hE5C}    // R8 step of generator
    };

    // reference: carry-less product then top-down reduction
    function automatic logic [5:0] ref_mul6(input logic [5:0] a, input logic [5:0] b);
        logic [10:0] t = '0;
        for (int i = 0; i < 6; i++)
            if (a[i]) t = t ^ (11'(b) << i);
        for (int k = 10; k >= 6; k--)
            if (t[k]) t = t ^ (11'h43 << (k - 6));
        return t[5:0];
    endfunction

    function automatic logic [11:0] ref_mul12(input logic [11:0] a, input logic [11:0] b);
        logic [5:0] ll = ref_mul6(a[5:0], b[5:0]);
        logic [5:0] hh = ref_mul6(a[11:6], b[11:6]);
        logic [5:0] ss = ref_mul6(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]);
        return {ss ^ ll, ref_mul6(hh, 6'h21) ^ ll};
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    // drive at negedge, one register stage, sample at next negedge
    task automatic apply(input logic st, input logic [11:0] a, input logic [11:0] b);
        in_valid = 1'b1;
        in_step  = st;
        in_a     = a;
        in_b     = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        logic [11:0] lf;
        logic [11:0] ab;
        logic [11:0] ba;
        logic [11:0] held;
        rst = 1'b1; in_valid = 1'b0; in_step = 1'b0; in_a = '0; in_b = '0;
        repeat (3) @(negedge clk);
        check("R1 valid", {11'd0, out_valid}, 12'd0);
        check("R1 prod", out_prod, 12'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][36], VEC[i][35:24], VEC[i][23:12]);
            check("R6 valid", {11'd0, out_valid}, 12'd1);
            check("R2/R3/R4/R5/R8 vector", out_prod, VEC[i][11:0]);
        end

        // R7: idle cycle with new operands leaves the product alone
        held = out_prod;
        in_a = 12'h777; in_b = 12'h333;
        @(negedge clk);
        check("R6 idle valid", {11'd0, out_valid}, 12'd0);
        check("R7 hold", out_prod, held);

        // R4 / R9 sweep against the reference model
        lf = 12'hACE;
        for (int n = 0; n < 300; n++) begin
            logic [11:0] a = lf;
            lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
            apply(1'b0, a, lf);
            ab = out_prod;
            check("R4 sweep", ab, ref_mul12(a, lf));
            apply(1'b0, lf, a);
            ba = out_prod;
            check("R9 swap", ba, ab);
            apply(1'b1, a, lf);
            check("R8 sweep", out_prod, (a == 12'd0) ? 12'h001 : ref_mul12(a, 12'hE01));
        end

        // R1: reset mid-stream clears the output
        in_valid = 1'b1; in_a = 12'h123; in_b = 12'h456; rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset prod", out_prod, 12'd0);
        check("R1 mid reset valid", {11'd0, out_valid}, 12'd0);
        rst = 1'b0; in_valid = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule